// File: doc/BRIEF.md
# MDIO Management Bus Master

This block lets a host reach the management registers of Ethernet PHYs through a two-wire serial bus: a clock line (MDC) and a shared bidirectional data line (MDIO, split into output, output enable and input). The host sees four 32-bit registers: configuration/status, control, data and address. It picks the frame flavour (Clause 22 or Clause 45), the MDC rate and the MDIO launch edge in the configuration register. The PHY and device/register numbers go in the control register. A frame is started by a register write. Writing the data register sends a write frame. Writing the control register with its read bit set sends a read frame. In Clause 45 mode, writing the address register sends an address frame.

A frame is 64 MDC periods long: 32 preamble ones, a start code, an opcode, two 5-bit address fields, a 2-bit turnaround and 16 data bits, all MSB first. Busy stays high for the whole frame, and MDC toggles only while busy is high. On a read, the master releases MDIO from the turnaround onward. It flags a read error when the PHY does not pull the second turnaround bit low, and it stores the 16 received bits in the data register.

Top module: `mdio_master`

## Requirements
- R1: After reset every register reads zero, MDC is low and MDIO is not driven.
- R2: Register select 0 is configuration/status: bit 0 busy (read-only), bit 1 read error (read-only), bit 6 Clause 45 mode, bits 15:8 divider, bit 23 falling-edge launch. Written fields read back unchanged.
- R3: A write to the data register (select 2) sends a write frame with these fields: 32 ones, start code 01, opcode 01, the PHY address (control bits 9:5), the register number (control bits 4:0), turnaround 10, then the written 16 bits. MDIO is driven for all 64 bits.
- R4: A write to the control register (select 1) with bit 15 set sends a read frame with opcode 10. MDIO is driven only for the first 46 bits. Data bits are sampled at MDC rising edges and land in the data register.
- R5: The read-error bit is set when the second turnaround bit of a read is not low. It is cleared when the next read frame starts.
- R6: In Clause 45 mode the start code is 00 and the opcodes are 00 for address, 01 for write and 11 for read. A write to the address register (select 3) sends an address frame that carries the written 16 bits.
- R7: In Clause 22 mode a write to the address register only stores the value and starts no frame.
- R8: Busy rises at the clock edge that accepts a starting write and falls after exactly 128 MDC half periods.
- R9: MDC idles low. Each half period lasts max(divider, 1) system clocks, and the first rising edge comes one half period after the frame starts.
- R10: With bit 23 set, MDIO changes only together with MDC falling edges. With bit 23 clear, MDIO changes only together with MDC rising edges.
- R11: While busy is high, every host register write is ignored. This includes a write in the final cycle of a frame.
- R12: A control write with bit 15 clear only updates the address fields and starts no frame. Bit 15 always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select: 0 config/status, 1 control, 2 data, 3 address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
The last clock edge of a read frame does two things at once: it clears busy and loads the sampled bits into the data register. A host data write that lands on that same edge must be dropped. The bench counts clocks from the frame start and places a data write exactly on the final edge. It then expects the register to hold the PHY's answer and busy to stay low. A second write one cycle later must be accepted and raise busy.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN   = 32;
  localparam int FIELD_W   = 5;
  localparam int DATA_W    = 16;
  localparam int HDR_LEN   = 4;
  localparam int FRAME_LEN = PRE_LEN + HDR_LEN + 2 * FIELD_W + 2 + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int TA_POS    = PRE_LEN + HDR_LEN + 2 * FIELD_W;
  localparam int DAT_POS   = TA_POS + 2;

  typedef enum logic [1:0] {
    FR_ADDR  = 2'd0,
    FR_WRITE = 2'd1,
    FR_READ  = 2'd2
  } frame_kind_e;

  typedef enum logic [1:0] {
    RG_CFG  = 2'd0,
    RG_CTL  = 2'd1,
    RG_DATA = 2'd2,
    RG_ADDR = 2'd3
  } reg_sel_e;

  // start code and opcode, packed as {st, op}
  function automatic logic [HDR_LEN-1:0] frame_header(input logic c45, input frame_kind_e k);
    logic [1:0] st;
    logic [1:0] op;
    st = c45 ? 2'b00 : 2'b01;
    case (k)
      FR_ADDR:  op = 2'b00;
      FR_WRITE: op = 2'b01;
      default:  op = c45 ? 2'b11 : 2'b10;
    endcase
    return {st, op};
  endfunction

  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic c45, input frame_kind_e k,
    input logic [FIELD_W-1:0] port, input logic [FIELD_W-1:0] dev,
    input logic [DATA_W-1:0] data);
    logic [1:0] ta;
    ta = (k == FR_READ) ? 2'b11 : 2'b10;
    return {{PRE_LEN{1'b1}}, frame_header(c45, k), port, dev, ta, data};
  endfunction

  // master owns the line for bit idx of a frame of kind k
  function automatic logic master_drives(input frame_kind_e k, input int idx);
    return (idx < FRAME_LEN) && ((k != FR_READ) || (idx < TA_POS));
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half;
  logic             mdc_q;
  logic             at_end;

  assign half      = (div == '0) ? DIV_W'(1) : div;
  assign at_end    = run && (cnt_q == half - DIV_W'(1));
  assign rise_tick = at_end && !mdc_q;
  assign fall_tick = at_end && mdc_q;
  assign mdc       = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (at_end) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  frame_kind_e        kind,
  input  logic               c45,
  input  logic               neg,
  input  logic [FIELD_W-1:0] port,
  input  logic [FIELD_W-1:0] dev,
  input  logic [DATA_W-1:0]  data,
  input  logic               mdc,
  input  logic               rise_tick,
  input  logic               fall_tick,
  input  logic               mdio_i,
  output logic               busy,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               rd_done,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_err,
  output logic [CNT_W-1:0]   bit_pos,
  output frame_kind_e        cur_kind
);
  logic                 busy_q;
  logic [CNT_W-1:0]     bit_q;
  frame_kind_e          kind_q;
  logic [FRAME_LEN-1:0] frame_q;
  logic [FRAME_LEN-1:0] shifted;
  logic [DATA_W-1:0]    shift_q;
  logic                 err_q;
  logic [CNT_W-1:0]     drv_idx;
  logic                 last_bit;
  logic                 is_read;

  assign last_bit = (bit_q == CNT_W'(FRAME_LEN - 1));
  assign is_read  = (kind_q == FR_READ);
  // rising-edge launch moves to the next bit as soon as MDC goes high
  assign drv_idx  = (!neg && mdc) ? bit_q + CNT_W'(1) : bit_q;
  assign shifted  = frame_q << drv_idx;
  assign mdio_o   = (!busy_q || drv_idx >= CNT_W'(FRAME_LEN)) ? 1'b1 : shifted[FRAME_LEN-1];
  assign mdio_oe  = busy_q && master_drives(kind_q, int'(drv_idx));
  assign rd_done  = busy_q && fall_tick && last_bit && is_read;
  assign busy     = busy_q;
  assign rd_data  = shift_q;
  assign rd_err   = err_q;
  assign bit_pos  = bit_q;
  assign cur_kind = kind_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      bit_q   <= '0;
      kind_q  <= FR_ADDR;
      frame_q <= '0;
      shift_q <= '0;
      err_q   <= 1'b0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q  <= 1'b1;
        bit_q   <= '0;
        kind_q  <= kind;
        frame_q <= build_frame(c45, kind, port, dev, data);
        if (kind == FR_READ) err_q <= 1'b0;
      end
    end else begin
      if (rise_tick && is_read) begin
        if (bit_q == CNT_W'(TA_POS + 1)) err_q <= mdio_i;
        if (bit_q >= CNT_W'(DAT_POS)) shift_q <= {shift_q[DATA_W-2:0], mdio_i};
      end
      if (fall_tick) begin
        if (last_bit) busy_q <= 1'b0;
        else          bit_q  <= bit_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [1:0]  host_sel,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int BUSY_BIT = 0;
  localparam int ERR_BIT  = 1;
  localparam int C45_BIT  = 6;
  localparam int DIV_LSB  = 8;
  localparam int NEG_BIT  = 23;
  localparam int RD_BIT   = 15;
  localparam int DEV_LSB  = 0;
  localparam int PORT_LSB = DEV_LSB + FIELD_W;

  logic               c45_q, neg_q;
  logic [DIV_W-1:0]   div_q;
  logic [FIELD_W-1:0] port_q, dev_q;
  logic [DATA_W-1:0]  data_q, addr_q;

  logic               busy, rd_err, rd_done;
  logic [DATA_W-1:0]  rd_data;
  logic               rise_tick, fall_tick;
  logic [CNT_W-1:0]   eng_bit;
  frame_kind_e        eng_kind;

  logic               accept, wr_cfg, wr_ctl, wr_data, wr_addr;
  logic               start_read, start_write, start_addr, frame_start;
  frame_kind_e        frame_kind;
  logic [FIELD_W-1:0] f_port, f_dev;

  assign accept      = host_we && !busy;
  assign wr_cfg      = accept && (reg_sel_e'(host_sel) == RG_CFG);
  assign wr_ctl      = accept && (reg_sel_e'(host_sel) == RG_CTL);
  assign wr_data     = accept && (reg_sel_e'(host_sel) == RG_DATA);
  assign wr_addr     = accept && (reg_sel_e'(host_sel) == RG_ADDR);
  assign start_read  = wr_ctl && host_wdata[RD_BIT];
  assign start_write = wr_data;
  assign start_addr  = wr_addr && c45_q;
  assign frame_start = start_read || start_write || start_addr;
  assign frame_kind  = start_read ? FR_READ : (start_write ? FR_WRITE : FR_ADDR);
  assign f_port      = wr_ctl ? host_wdata[PORT_LSB +: FIELD_W] : port_q;
  assign f_dev       = wr_ctl ? host_wdata[DEV_LSB +: FIELD_W] : dev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c45_q  <= 1'b0;
      neg_q  <= 1'b0;
      div_q  <= '0;
      port_q <= '0;
      dev_q  <= '0;
      data_q <= '0;
      addr_q <= '0;
    end else begin
      if (wr_cfg) begin
        c45_q <= host_wdata[C45_BIT];
        neg_q <= host_wdata[NEG_BIT];
        div_q <= host_wdata[DIV_LSB +: DIV_W];
      end
      if (wr_ctl) begin
        port_q <= host_wdata[PORT_LSB +: FIELD_W];
        dev_q  <= host_wdata[DEV_LSB +: FIELD_W];
      end
      if (wr_addr) addr_q <= host_wdata[DATA_W-1:0];
      if (wr_data)      data_q <= host_wdata[DATA_W-1:0];
      else if (rd_done) data_q <= rd_data;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (reg_sel_e'(host_sel))
      RG_CFG: begin
        host_rdata[BUSY_BIT]              = busy;
        host_rdata[ERR_BIT]               = rd_err;
        host_rdata[C45_BIT]               = c45_q;
        host_rdata[NEG_BIT]               = neg_q;
        host_rdata[DIV_LSB +: DIV_W]      = div_q;
      end
      RG_CTL: begin
        host_rdata[PORT_LSB +: FIELD_W]   = port_q;
        host_rdata[DEV_LSB +: FIELD_W]    = dev_q;
      end
      RG_DATA: host_rdata[DATA_W-1:0]     = data_q;
      default: host_rdata[DATA_W-1:0]     = addr_q;
    endcase
  end

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .div       (div_q),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_eng u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (frame_start),
    .kind      (frame_kind),
    .c45       (c45_q),
    .neg       (neg_q),
    .port      (f_port),
    .dev       (f_dev),
    .data      (host_wdata[DATA_W-1:0]),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rd_done   (rd_done),
    .rd_data   (rd_data),
    .rd_err    (rd_err),
    .bit_pos   (eng_bit),
    .cur_kind  (eng_kind)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               mdc,
  input logic               mdio_o,
  input logic               mdio_oe,
  input logic               host_we,
  input logic [1:0]         host_sel,
  input logic               frame_start,
  input frame_kind_e        frame_kind,
  input logic               rd_err,
  input logic [CNT_W-1:0]   eng_bit,
  input frame_kind_e        eng_kind,
  input logic               c45_q,
  input logic               neg_q,
  input logic [DIV_W-1:0]   div_q,
  input logic [FIELD_W-1:0] port_q,
  input logic [FIELD_W-1:0] dev_q,
  input logic [DATA_W-1:0]  addr_q
);
  a_r9_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  a_r1_line_free_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> busy);

  a_r3_driven_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_kind != FR_READ && eng_bit < CNT_W'(FRAME_LEN - 1)) |-> mdio_oe);

  a_r4_released_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_kind == FR_READ && eng_bit >= CNT_W'(TA_POS + 1)) |-> !mdio_oe);

  a_r5_err_cleared_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && frame_kind == FR_READ) |=> !rd_err);

  a_r7_no_addr_frame_c22: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !busy && host_sel == 2'd3 && !c45_q) |=> !busy);

  a_r10_neg_holds_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && neg_q && $past(busy) && mdc) |-> $stable(mdio_o));

  a_r11_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(port_q) && $stable(dev_q) && $stable(addr_q) &&
              $stable(c45_q) && $stable(neg_q) && $stable(div_q)));
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .mdc         (mdc),
  .mdio_o      (mdio_o),
  .mdio_oe     (mdio_oe),
  .host_we     (host_we),
  .host_sel    (host_sel),
  .frame_start (frame_start),
  .frame_kind  (frame_kind),
  .rd_err      (rd_err),
  .eng_bit     (eng_bit),
  .eng_kind    (eng_kind),
  .c45_q       (c45_q),
  .neg_q       (neg_q),
  .div_q       (div_q),
  .port_q      (port_q),
  .dev_q       (dev_q),
  .addr_q      (addr_q)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  haddr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  mdio_master u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(wr_en), .host_sel(haddr),
    .host_wdata(wdata), .host_rdata(rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // vector: kind(2) c45 neg div(8) port(5) dev(5) data(16) respond
  localparam int NV = 6;
  localparam logic [38:0] VEC [NV] = '{
    {2'd1, 1'b0, 1'b0, 8'd2, 5'h01, 5'h02, 16'hA5C3, 1'b0},
    {2'd2, 1'b0, 1'b0, 8'd3, 5'h11, 5'h04, 16'h0000, 1'b0},
    {2'd2, 1'b0, 1'b1, 8'd1, 5'h1F, 5'h00, 16'h1234, 1'b1},
    {2'd0, 1'b1, 1'b0, 8'd0, 5'h03, 5'h01, 16'h8001, 1'b0},
    {2'd1, 1'b1, 1'b1, 8'd2, 5'h03, 5'h01, 16'h0F0F, 1'b0},
    {2'd2, 1'b1, 1'b0, 8'd1, 5'h03, 5'h07, 16'hBEEF, 1'b1}
  };

  // monitor / PHY responder state
  int          cyc = 0;
  int          rise_cnt = 0;
  int          first_rise = 0;
  int          end_cyc = 0;
  int          n_end = 0;
  int          edge_viol = 0;
  logic        busy_prev = 1'b0;
  logic        prev_mdc = 1'b0;
  logic        prev_o = 1'b1;
  logic        prev_oe = 1'b0;
  logic [63:0] cap = '0;
  logic [63:0] cap_oe = '0;
  logic        cur_neg = 1'b0;
  logic        resp_en = 1'b0;
  logic [15:0] resp_data = '0;

  function automatic logic resp_bit(input int r);
    if (!resp_en || r < 47 || r >= 64) return 1'b1;
    if (r == 47) return 1'b0;
    return resp_data[15 - (r - 48)];
  endfunction

  always begin
    logic busy_now;
    @(posedge clk);
    #1;
    cyc++;
    busy_now = (haddr == 2'd0 && !wr_en) ? rdata[0] : busy_prev;
    if (busy_now && !busy_prev) begin
      rise_cnt = 0; cap = '0; cap_oe = '0; edge_viol = 0; first_rise = 0;
    end
    if (busy_now && busy_prev && (mdio_o !== prev_o) && (cur_neg ? mdc : !mdc))
      edge_viol++;
    if (mdc && !prev_mdc) begin
      if (rise_cnt == 0) first_rise = cyc;
      if (rise_cnt < 64) begin
        cap[63 - rise_cnt]    = prev_o;
        cap_oe[63 - rise_cnt] = prev_oe;
      end
      rise_cnt++;
    end
    if (!busy_now && busy_prev) begin
      end_cyc = cyc;
      n_end++;
    end
    mdio_i    = resp_bit(rise_cnt);
    busy_prev = busy_now;
    prev_mdc  = mdc;
    prev_o    = mdio_o;
    prev_oe   = mdio_oe;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; haddr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; haddr = 2'd0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
    haddr = a;
    #0.5;
    v = rdata;
    haddr = 2'd0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    do begin
      @(negedge clk);
      rd_reg(2'd0, v);
    end while (v[0]);
  endtask

  function automatic logic [31:0] cfg_word(input logic c45, input logic neg, input logic [7:0] dv);
    logic [31:0] w;
    w = '0;
    w[23] = neg;
    w[15:8] = dv;
    w[6] = c45;
    return w;
  endfunction

  function automatic logic [63:0] ref_frame(input logic [1:0] kind, input logic c45,
      input logic [4:0] port, input logic [4:0] dev, input logic [15:0] d);
    logic [63:0] f;
    f = 64'hFFFF_FFFF_0000_0000;
    f[31:30] = c45 ? 2'b00 : 2'b01;
    f[29:28] = (kind == 2'd0) ? 2'b00 : (kind == 2'd1) ? 2'b01 : (c45 ? 2'b11 : 2'b10);
    f[27:23] = port;
    f[22:18] = dev;
    f[17:16] = 2'b10;
    f[15:0]  = d;
    return f;
  endfunction

  function automatic int half_of(input logic [7:0] dv);
    return (dv == 8'd0) ? 1 : int'(dv);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    int c0, h;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(2'd0, v); chk("R1 cfg", v, 0);
    rd_reg(2'd1, v); chk("R1 ctl", v, 0);
    rd_reg(2'd2, v); chk("R1 data", v, 0);
    rd_reg(2'd3, v); chk("R1 addr", v, 0);
    chk("R1 mdc/oe", {mdc, mdio_oe}, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [1:0] kind; logic c45, neg, resp; logic [7:0] dv;
      logic [4:0] port, dev; logic [15:0] dat; logic [63:0] mask, exp_oe;
      {kind, c45, neg, dv, port, dev, dat, resp} = VEC[i];
      h = half_of(dv);
      cur_neg = neg;
      resp_en = resp;
      resp_data = dat;
      host_write(2'd0, cfg_word(c45, neg, dv));
      rd_reg(2'd0, v);
      chk("R2 cfg readback", v & 32'h0080_FF41, cfg_word(c45, neg, dv));
      case (kind)
        2'd1: begin
          host_write(2'd1, {22'd0, port, dev});
          host_write(2'd2, {16'd0, dat});
        end
        2'd2: host_write(2'd1, {16'd0, 1'b1, 5'd0, port, dev});
        default: begin
          host_write(2'd1, {22'd0, port, dev});
          host_write(2'd3, {16'd0, dat});
        end
      endcase
      c0 = cyc;
      wait_idle();
      chk("R9 first rise", 64'(first_rise - c0), 64'(h));
      chk("R8 frame length", 64'(end_cyc - c0), 64'(128 * h));
      mask   = (kind == 2'd2) ? {{46{1'b1}}, 18'd0} : '1;
      exp_oe = mask;
      chk(c45 ? "R6 frame bits" : "R3/R4 frame bits", cap & mask,
          ref_frame(kind, c45, port, dev, dat) & mask);
      chk("R3/R4 line ownership", cap_oe, exp_oe);
      chk("R10 launch edge", 64'(edge_viol), 0);
      if (kind == 2'd2) begin
        rd_reg(2'd0, v); chk("R5 read error", 64'(v[1]), 64'(!resp));
        rd_reg(2'd2, v); chk("R4 read data", v, resp ? {16'd0, dat} : 32'h0000_FFFF);
      end else if (kind == 2'd1) begin
        rd_reg(2'd2, v); chk("R3 data reg", v, {16'd0, dat});
      end else begin
        rd_reg(2'd3, v); chk("R6 addr reg", v, {16'd0, dat});
      end
    end

    // R12 control write without read bit
    host_write(2'd0, cfg_word(1'b0, 1'b0, 8'd1));
    host_write(2'd1, {16'd0, 1'b0, 5'd0, 5'h0A, 5'h15});
    rd_reg(2'd0, v); chk("R12 no frame", 64'(v[0]), 0);
    rd_reg(2'd1, v); chk("R12 ctl readback", v, {22'd0, 5'h0A, 5'h15});
    host_write(2'd1, {16'd0, 1'b1, 5'd0, 5'h0A, 5'h15});
    rd_reg(2'd1, v); chk("R12 read bit reads 0", 64'(v[15]), 0);
    wait_idle();

    // R7 address write in Clause 22 mode
    host_write(2'd3, 32'h0000_7777);
    rd_reg(2'd0, v); chk("R7 no frame", 64'(v[0]), 0);
    repeat (4) @(negedge clk);
    chk("R7 mdc quiet", 64'(mdc), 0);
    rd_reg(2'd3, v); chk("R7 addr stored", v, 32'h0000_7777);

    // R11 writes while busy are dropped
    cur_neg = 1'b0;
    resp_en = 1'b0;
    host_write(2'd1, {22'd0, 5'h02, 5'h03});
    host_write(2'd2, 32'h0000_C0DE);
    c0 = cyc;
    repeat (10) @(negedge clk);
    host_write(2'd2, 32'h0000_1111);
    host_write(2'd1, {16'd0, 1'b1, 5'd0, 10'h3FF});
    host_write(2'd0, cfg_word(1'b1, 1'b1, 8'd5));
    host_write(2'd3, 32'h0000_2222);
    wait_idle();
    chk("R11 frame length kept", 64'(end_cyc - c0), 128);
    rd_reg(2'd2, v); chk("R11 data kept", v, 32'h0000_C0DE);
    rd_reg(2'd1, v); chk("R11 ctl kept", v, {22'd0, 5'h02, 5'h03});
    rd_reg(2'd0, v); chk("R11 cfg kept", v & 32'h0080_FF41, cfg_word(1'b0, 1'b0, 8'd1));
    rd_reg(2'd3, v); chk("R11 addr kept", v, 32'h0000_7777);

    // R11 write on the final edge of a read frame
    resp_en = 1'b1;
    resp_data = 16'h5A5A;
    host_write(2'd1, {16'd0, 1'b1, 5'd0, 5'h04, 5'h09});
    repeat (126) @(negedge clk);
    host_write(2'd2, 32'h0000_0BAD);
    rd_reg(2'd2, v); chk("R11 end-edge write dropped", v, 32'h0000_5A5A);
    rd_reg(2'd0, v); chk("R11 no new frame", 64'(v[0]), 0);
    resp_en = 1'b0;
    host_write(2'd2, 32'h0000_0BAD);
    rd_reg(2'd0, v); chk("R8 next write accepted", 64'(v[0]), 1);
    wait_idle();
    rd_reg(2'd2, v); chk("R3 data after write", v, 32'h0000_0BAD);

    summary();
  end
endmodule